// File: doc/BRIEF.md
# Grouped Level Interrupt Combiner

This block collects level-sensitive interrupt sources and folds them into a small number of request lines for a parent interrupt controller. Sources are arranged in banks of 32. Inside a bank, each byte lane of eight sources forms one group, and each group drives its own request output. A group request is high whenever at least one of its sources is both raised and enabled. Software reads a per-bank status word and picks the lowest set bit in the group's byte to find the source that fired.

Each source has one enable bit. Software never writes the enable word directly. It writes ones to a set address to turn sources on, and ones to a clear address to turn them off. Zero bits in either write leave their enables alone, so two agents can manage different sources without a read-modify-write race. Each bank's registers take a 16-byte window, and successive banks follow one another at a 0x10 stride. The register port is plain: single-cycle write and read strobes, a byte address, and 32-bit data. Read data is registered.

Top module: `irq_group_combiner`

## Requirements
- R1: While reset is asserted and right after it, every enable bit is 0, every group output is 0, and a read of any bank's status word or enable word returns 0.
- R2: A write to bank offset 0x0 (set) turns on each source whose data bit is 1. Sources whose data bit is 0 keep their previous enable value.
- R3: A write to bank offset 0x4 (clear) turns off each source whose data bit is 1. Sources whose data bit is 0 keep their previous enable value.
- R4: A read of bank offset 0xC returns the status word. Bit i of that word is raw source i AND enable i.
- R5: Group g of bank b (g = 0..3) covers status bits 8g to 8g+7 of that bank. It drives output bit grp_irq[4b+g], which is the OR of those eight status bits.
- R6: Group outputs are level-sensitive and combinational from the raw sources. An output goes high in the same cycle that an enabled source rises, stays high for as long as that source is held, and drops in the same cycle it falls.
- R7: Bank b is decoded at byte address 0x10*b plus the offset (address bits [3:0]). A write to one bank never changes another bank's enables.
- R8: A read of offset 0x0 or 0x4 returns the bank's enable word. A read of any other offset, or of a bank index at or above NUM_BANKS, returns 0. Writes to offsets other than 0x0 and 0x4, or to such banks, change no enable bit.
- R9: rdata holds the read result in the cycle after rd_en is sampled high and is 0 in every cycle that does not follow a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | ADDR_W | Byte address: bank in bits [ADDR_W-1:4], offset in bits [3:0] |
| wdata | input | 32 | Write data, one bit per source of the addressed bank |
| rdata | output | 32 | Registered read data |
| src_raw | input | 32*NUM_BANKS | Raw level sources; bank b uses bits [32b+31:32b] |
| grp_irq | output | 4*NUM_BANKS | Group requests; bit 4b+g belongs to group g of bank b |

## Verification
The bench builds the block with NUM_BANKS=2 and ADDR_W=8. With these values it can walk every one of the 64 sources through set, status and clear, and can observe which of the eight group outputs lights up each time. The 8-bit address also reaches bank index 2 and above, beyond the last bank, so the bench can show that such accesses return 0 and have no effect. A sweep of computed enable and raw patterns exercises every byte lane of both banks against an arithmetic model of the group OR.

// File: rtl/irq_group_combiner_pkg.sv
package irq_group_combiner_pkg;
  localparam int          LANE_W     = 8;
  localparam int          LANES      = 4;
  localparam int          BANK_W     = LANE_W * LANES;
  localparam int          OFS_W      = 4;
  localparam logic [3:0]  OFS_EN_SET = 4'h0;
  localparam logic [3:0]  OFS_EN_CLR = 4'h4;
  localparam logic [3:0]  OFS_STATUS = 4'hC;

  typedef enum logic [1:0] {
    RK_NONE,
    RK_ENABLE,
    RK_STATUS
  } rd_kind_e;
endpackage

// File: rtl/icomb_bank.sv
module icomb_bank
  import irq_group_combiner_pkg::*;
#(
  parameter int GRP_W  = LANE_W,
  parameter int GRPS   = LANES,
  localparam int SRC_N = GRP_W * GRPS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [SRC_N-1:0] wdata,
  input  logic [SRC_N-1:0] raw,
  output logic [SRC_N-1:0] en_q,
  output logic [SRC_N-1:0] status,
  output logic [GRPS-1:0]  grp
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (set_we) en_q <= en_q | wdata;
    else if (clr_we) en_q <= en_q & ~wdata;
  end

  assign status = raw & en_q;

  for (genvar g = 0; g < GRPS; g++) begin : g_lane
    assign grp[g] = |status[g*GRP_W +: GRP_W];
  end
endmodule

// File: rtl/icomb_wr_dec.sv
module icomb_wr_dec
  import irq_group_combiner_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8,
  localparam int BIDX_W   = ADDR_W - OFS_W
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_BANKS-1:0] set_we,
  output logic [NUM_BANKS-1:0] clr_we
);
  logic [BIDX_W-1:0] bidx;
  logic [OFS_W-1:0]  ofs;

  assign bidx = addr[ADDR_W-1:OFS_W];
  assign ofs  = addr[OFS_W-1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit       = wr_en && (bidx == BIDX_W'(b));
    assign set_we[b] = hit && (ofs == OFS_EN_SET);
    assign clr_we[b] = hit && (ofs == OFS_EN_CLR);
  end
endmodule

// File: rtl/icomb_rd_mux.sv
module icomb_rd_mux
  import irq_group_combiner_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8,
  localparam int BIDX_W   = ADDR_W - OFS_W,
  localparam int TOT_W    = BANK_W * NUM_BANKS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TOT_W-1:0]  en_all,
  input  logic [TOT_W-1:0]  status_all,
  output logic [BANK_W-1:0] rdata
);
  logic [BIDX_W-1:0] bidx;
  logic [OFS_W-1:0]  ofs;
  rd_kind_e          kind;
  logic [BANK_W-1:0] sel_en, sel_st, rd_next;

  assign bidx = addr[ADDR_W-1:OFS_W];
  assign ofs  = addr[OFS_W-1:0];

  always_comb begin
    unique case (ofs)
      OFS_EN_SET, OFS_EN_CLR: kind = RK_ENABLE;
      OFS_STATUS:             kind = RK_STATUS;
      default:                kind = RK_NONE;
    endcase
  end

  always_comb begin
    sel_en = '0;
    sel_st = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bidx == BIDX_W'(b)) begin
        sel_en = en_all[b*BANK_W +: BANK_W];
        sel_st = status_all[b*BANK_W +: BANK_W];
      end
    end
  end

  always_comb begin
    case (kind)
      RK_ENABLE: rd_next = sel_en;
      RK_STATUS: rd_next = sel_st;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_next;
    else            rdata <= '0;
  end
endmodule

// File: rtl/irq_group_combiner.sv
module irq_group_combiner
  import irq_group_combiner_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8,
  localparam int TOT_W    = BANK_W * NUM_BANKS,
  localparam int GRP_N    = LANES * NUM_BANKS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [TOT_W-1:0]  src_raw,
  output logic [GRP_N-1:0]  grp_irq
);
  logic [NUM_BANKS-1:0] set_we, clr_we;
  logic [TOT_W-1:0]     en_all, status_all;

  icomb_wr_dec #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_wr_dec (
    .wr_en  (wr_en),
    .addr   (addr),
    .set_we (set_we),
    .clr_we (clr_we)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    icomb_bank #(.GRP_W(LANE_W), .GRPS(LANES)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (set_we[b]),
      .clr_we (clr_we[b]),
      .wdata  (wdata),
      .raw    (src_raw[b*BANK_W +: BANK_W]),
      .en_q   (en_all[b*BANK_W +: BANK_W]),
      .status (status_all[b*BANK_W +: BANK_W]),
      .grp    (grp_irq[b*LANES +: LANES])
    );
  end

  icomb_rd_mux #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_rd_mux (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .addr       (addr),
    .en_all     (en_all),
    .status_all (status_all),
    .rdata      (rdata)
  );
endmodule

// File: rtl/irq_group_combiner_chk.sv
module irq_group_combiner_chk #(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8,
  localparam int TOT_W    = 32 * NUM_BANKS,
  localparam int GRP_N    = 4 * NUM_BANKS
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic [TOT_W-1:0]  src_raw,
  input logic [GRP_N-1:0]  grp_irq,
  input logic [TOT_W-1:0]  en_all
);
  always @(negedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (grp_irq == '0 && en_all == '0); // R1
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(b * 16);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(b * 16 + 4);

    AST_SET_ORS_IN: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_SET) |=>
        en_all[b*32 +: 32] == ($past(en_all[b*32 +: 32]) | $past(wdata))); // R2

    AST_CLR_MASKS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_CLR) |=>
        en_all[b*32 +: 32] == ($past(en_all[b*32 +: 32]) & ~$past(wdata))); // R3

    AST_OTHER_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (addr == A_SET || addr == A_CLR)) |=>
        $stable(en_all[b*32 +: 32])); // R7
  end

  AST_LEVEL_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    (|grp_irq) == (|(src_raw & en_all))); // R6

  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> rdata == 32'h0); // R9
endmodule

bind irq_group_combiner irq_group_combiner_chk #(
  .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .wdata   (wdata),
  .rdata   (rdata),
  .src_raw (src_raw),
  .grp_irq (grp_irq),
  .en_all  (en_all)
);

// File: tb/irq_group_combiner_bench.sv
`timescale 1ns/1ps
module irq_group_combiner_bench;
  localparam int NB = 2;
  localparam int AW = 8;
  localparam int TW = 32 * NB;
  localparam int GN = 4 * NB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [TW-1:0] src_raw = '0;
  logic [GN-1:0] grp_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] model_en [NB];

  always #10 clk = ~clk;

  irq_group_combiner #(.NUM_BANKS(NB), .ADDR_W(AW)) u_irq_group_combiner (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .src_raw(src_raw), .grp_irq(grp_irq)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  function automatic logic [GN-1:0] exp_grp();
    logic [GN-1:0] r = '0;
    for (int b = 0; b < NB; b++)
      for (int g = 0; g < 4; g++)
        r[b*4+g] = |((src_raw[b*32 + g*8 +: 8]) & model_en[b][g*8 +: 8]);
    return r;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    for (int b = 0; b < NB; b++) model_en[b] = '0;
    repeat (3) @(negedge clk);
    check("R1 grp during reset", 64'(grp_irq), 64'h0);
    rst_n = 1'b1;
    src_raw = '1;
    #1;
    check("R1 grp after reset", 64'(grp_irq), 64'h0);
    for (int b = 0; b < NB; b++) begin
      do_rd(AW'(b*16), d);      check("R1 enable word", 64'(d), 64'h0);
      do_rd(AW'(b*16 + 12), d); check("R1 status word", 64'(d), 64'h0);
    end

    // Walk every source through set/status/clear.
    for (int b = 0; b < NB; b++) begin
      for (int i = 0; i < 32; i++) begin
        src_raw = TW'(1) << (b*32 + i);
        do_wr(AW'(b*16), 32'(1) << i);
        #1;
        check("R5 single source group", 64'(grp_irq), 64'(GN'(1) << (b*4 + i/8)));
        do_rd(AW'(b*16), d);      check("R2 set readback", 64'(d), 64'(32'(1) << i));
        do_rd(AW'(b*16 + 4), d);  check("R8 clear-offset readback", 64'(d), 64'(32'(1) << i));
        do_rd(AW'(b*16 + 12), d); check("R4 status one bit", 64'(d), 64'(32'(1) << i));
        do_rd(AW'((1-b)*16), d);  check("R7 other bank untouched", 64'(d), 64'h0);
        do_wr(AW'(b*16 + 4), 32'(1) << i);
        #1;
        check("R3 cleared group low", 64'(grp_irq), 64'h0);
        do_rd(AW'(b*16), d);      check("R3 enable cleared", 64'(d), 64'h0);
      end
    end

    // Partial set / clear preserve other bits.
    do_wr(8'h00, 32'hF0F0_0F0F); model_en[0] = 32'hF0F0_0F0F;
    do_wr(8'h00, 32'h0000_00F0); model_en[0] = model_en[0] | 32'h0000_00F0;
    do_rd(8'h00, d); check("R2 set keeps zeros", 64'(d), 64'(model_en[0]));
    do_wr(8'h04, 32'h0F00_0003); model_en[0] = model_en[0] & ~32'h0F00_0003;
    do_rd(8'h04, d); check("R3 clear keeps zeros", 64'(d), 64'(model_en[0]));

    // Unmapped offsets and banks.
    do_rd(8'h08, d); check("R8 offset 8 reads zero", 64'(d), 64'h0);
    do_wr(8'h08, 32'hFFFF_FFFF);
    do_wr(8'h0C, 32'hFFFF_FFFF);
    do_wr(8'h20, 32'hFFFF_FFFF);
    do_wr(8'h24, 32'hFFFF_FFFF);
    do_rd(8'h00, d); check("R8 bank0 unchanged", 64'(d), 64'(model_en[0]));
    do_rd(8'h10, d); check("R8 bank1 unchanged", 64'(d), 64'(model_en[1]));
    do_rd(8'h20, d); check("R8 bank beyond range reads zero", 64'(d), 64'h0);
    do_rd(8'h2C, d); check("R8 status beyond range reads zero", 64'(d), 64'h0);
    @(negedge clk);
    check("R9 rdata zero after read", 64'(rdata), 64'h0);
    do_rd(8'h00, d);
    check("R9 rdata valid in cycle after strobe", 64'(d), 64'(model_en[0]));

    // Level behaviour.
    do_wr(8'h14, 32'hFFFF_FFFF); model_en[1] = '0;
    do_wr(8'h10, 32'h0000_0100); model_en[1] = 32'h0000_0100;
    @(negedge clk);
    src_raw = TW'(1) << (32 + 8);
    #1; check("R6 rises same cycle", 64'(grp_irq), 64'(exp_grp()));
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R6 held while source high", 64'(grp_irq[5]), 64'h1);
    end
    src_raw = '0;
    #1; check("R6 drops same cycle", 64'(grp_irq), 64'h0);

    // Pattern sweep over both banks.
    for (int k = 0; k < 24; k++) begin
      for (int b = 0; b < NB; b++) begin
        logic [31:0] p;
        p = (32'h9E37_79B9 * 32'(k + 1 + b*7)) ^ (32'h0101_0101 << (k % 8));
        do_wr(AW'(b*16 + 4), 32'hFFFF_FFFF);
        do_wr(AW'(b*16), p);
        model_en[b] = p;
      end
      @(negedge clk);
      src_raw = {32'h3C5A_A5C3 ^ 32'(k * 32'h0003_1337), 32'h8421_1248 ^ 32'(k * 32'h0010_2405)};
      #1;
      check("R5 pattern group outputs", 64'(grp_irq), 64'(exp_grp()));
      for (int b = 0; b < NB; b++) begin
        do_rd(AW'(b*16 + 12), d);
        check("R4 pattern status", 64'(d), 64'(src_raw[b*32 +: 32] & model_en[b]));
      end
    end

    finish_run();
  end
endmodule